// File: doc/BRIEF.md
# Interrupt Priority and Acknowledge Core

This block holds the request and in-service state of an eight-line interrupt controller and decides when the processor should be interrupted. A one-cycle pulse on an input line is ignored when that line's mask bit is 1. Otherwise the pulse latches a pending request. Priority is fixed: line 7 is the highest and line 0 the lowest. A pending request is forwarded only when no in-service line at or above it is active. When it is forwarded, a registered interrupt level is raised toward the processor.

When the processor strobes acknowledge, the block takes the highest pending line and clears its request. It then either marks the line in service or, in automatic end-of-interrupt mode, retires it at once. In the next cycle it presents an 8-bit vector. If the chosen line is wired to a cascaded controller and that controller is present, the block raises a flag telling the caller to fetch the vector from there instead. End-of-interrupt commands clear an in-service bit. A command can name its line, or it can target the highest line in service. After every event the forwarding decision is made again from the updated registers.

The controller is a two-state machine. In state QUIET the interrupt output is low; in state RAISED it is high. Transition RAISE (QUIET to RAISED) is taken when the register values written at an edge hold a forwardable request. Transition DROP (RAISED to QUIET) is taken when they do not. Otherwise the state holds: QUIET_HOLD and RAISED_HOLD.

Top module: `irq_prio_core`

## Requirements
- R1: After reset the interrupt output is 0, the vector-valid output is 0, and no request or in-service bit is set.
- R2: A pulse on a line whose mask bit is 1 leaves that line's request bit clear and does not raise the interrupt output.
- R3: A pulse on an unmasked line sets its request bit. When no in-service bit is set, the interrupt output is 1 in the cycle after the pulse edge.
- R4: A pending request on line n is not forwarded while any in-service bit n through 7 is set. A request on a line above every in-service bit is forwarded.
- R5: Acknowledge chooses the highest-numbered pending line. One cycle after the acknowledge edge, vector-valid is 1 for one cycle and the vector is the base with its low 3 bits replaced by the line number.
- R6: Acknowledge clears the chosen request bit. With automatic EOI off it sets that line's in-service bit.
- R7: With automatic EOI on, acknowledge sets no in-service bit, so lower lines can still be forwarded.
- R8: The slave flag is 1 with the vector when the chosen line's bit in the cascade map is 1 and slave-present is 1. Otherwise it is 0.
- R9: Acknowledge with no pending request returns base with low bits 7, slave flag 0, and changes no request or in-service bit.
- R10: A specific EOI clears the named line's in-service bit. The highest pending request is then evaluated again and may raise the output.
- R11: A non-specific EOI clears the highest-numbered set in-service bit.
- R12: A pulse arriving in the same cycle as an acknowledge keeps its new request bit.
- R13: Once raised, the interrupt output stays 1 until an acknowledge, with no other event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pulse | input | 8 | One-cycle request pulse per line |
| mask | input | 8 | Per-line mask, 1 = ignore pulses |
| vec_base | input | 8 | Vector base; low 3 bits are replaced |
| auto_eoi | input | 1 | 1 = retire the line on acknowledge |
| cascade_map | input | 8 | 1 = line is fed by a cascaded controller |
| slave_present | input | 1 | A cascaded controller is attached |
| ack | input | 1 | Acknowledge strobe |
| eoi_valid | input | 1 | End-of-interrupt command strobe |
| eoi_specific | input | 1 | 1 = use eoi_line, 0 = highest in service |
| eoi_line | input | 3 | Line for a specific EOI |
| int_out | output | 1 | Registered interrupt level |
| vec_valid | output | 1 | Vector returned this cycle |
| vec_out | output | 8 | Returned vector |
| vec_from_slave | output | 1 | Fetch vector from the cascaded controller |

## Verification
Three events can fall on the same edge: a new request pulse, an acknowledge and an EOI. The pulse-plus-acknowledge case is the one that can lose data, because the acknowledge clears a request bit in the same register that the pulse sets. The bench first latches line 6, then drives a pulse on line 0 and the acknowledge strobe in the same cycle. It expects vector 6 back. It then retires line 6 and expects the output to rise again and a second acknowledge to return line 0, which proves the new request survived.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic {
        ST_QUIET  = 1'b0,
        ST_RAISED = 1'b1
    } irq_state_e;
endpackage

// File: rtl/irq_pick.sv
// Highest-set-bit finder: the upper index wins.
module irq_pick #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  bits_in,
    output logic          any,
    output logic [IW-1:0] top
);
    always_comb begin
        top = '0;
        for (int i = 0; i < N; i++) begin
            if (bits_in[i]) top = IW'(i);
        end
    end
    assign any = |bits_in;
endmodule

// File: rtl/irq_req_bank.sv
// Pending-request register.
module irq_req_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pulse,
    input  logic [N-1:0] mask,
    input  logic [N-1:0] clr,
    output logic [N-1:0] req_d,
    output logic [N-1:0] req_q
);
    // a pulse beats a same-cycle clear of the same line
    assign req_d = (req_q & ~clr) | (pulse & ~mask);

    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end
endmodule

// File: rtl/irq_svc_bank.sv
// In-service register.
module irq_svc_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_v,
    input  logic [N-1:0] clr,
    output logic [N-1:0] svc_d,
    output logic [N-1:0] svc_q
);
    assign svc_d = (svc_q & ~clr) | set_v;

    always_ff @(posedge clk) begin
        if (!rst_n) svc_q <= '0;
        else        svc_q <= svc_d;
    end
endmodule

// File: rtl/irq_fwd_check.sv
// Decides whether the top pending line clears every in-service line at or above it.
module irq_fwd_check #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] req,
    input  logic [N-1:0] svc,
    output logic         fwd
);
    logic          any;
    logic [IW-1:0] top;
    logic [N-1:0]  upper;

    irq_pick #(.N(N)) u_pick (
        .bits_in (req),
        .any     (any),
        .top     (top)
    );

    for (genvar g = 0; g < N; g++) begin : g_upper
        assign upper[g] = (IW'(g) >= top);
    end

    assign fwd = any && ((svc & upper) == '0);
endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core #(
    parameter int N     = 8,
    parameter int VEC_W = 8,
    localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     irq_pulse,
    input  logic [N-1:0]     mask,
    input  logic [VEC_W-1:0] vec_base,
    input  logic             auto_eoi,
    input  logic [N-1:0]     cascade_map,
    input  logic             slave_present,
    input  logic             ack,
    input  logic             eoi_valid,
    input  logic             eoi_specific,
    input  logic [IW-1:0]    eoi_line,
    output logic             int_out,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vec_out,
    output logic             vec_from_slave
);
    import irq_pkg::*;

    logic [N-1:0]  req_d, req_q, svc_d, svc_q;
    logic [N-1:0]  ack_clr, ack_set, eoi_clr;
    logic          req_any, svc_any, ack_take, fwd_next;
    logic [IW-1:0] req_top, svc_top, eoi_idx;
    irq_state_e    state, state_nx;

    irq_pick #(.N(N)) u_req_pick (.bits_in(req_q), .any(req_any), .top(req_top));
    irq_pick #(.N(N)) u_svc_pick (.bits_in(svc_q), .any(svc_any), .top(svc_top));

    // acknowledge: retire the top request, optionally mark it in service
    assign ack_take = ack && req_any;
    assign ack_clr  = ack_take ? (N'(1) << req_top) : '0;
    assign ack_set  = (ack_take && !auto_eoi) ? (N'(1) << req_top) : '0;

    // EOI: named line, or top in-service line
    assign eoi_idx  = eoi_specific ? eoi_line : svc_top;
    assign eoi_clr  = (eoi_valid && (eoi_specific || svc_any)) ? (N'(1) << eoi_idx) : '0;

    irq_req_bank #(.N(N)) u_req (
        .clk(clk), .rst_n(rst_n), .pulse(irq_pulse), .mask(mask),
        .clr(ack_clr), .req_d(req_d), .req_q(req_q)
    );

    irq_svc_bank #(.N(N)) u_svc (
        .clk(clk), .rst_n(rst_n), .set_v(ack_set), .clr(eoi_clr),
        .svc_d(svc_d), .svc_q(svc_q)
    );

    irq_fwd_check #(.N(N)) u_fwd (.req(req_d), .svc(svc_d), .fwd(fwd_next));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_QUIET;
        else        state <= state_nx;
    end

    // transitions: RAISE, DROP, QUIET_HOLD, RAISED_HOLD
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_QUIET:  if (fwd_next)  state_nx = ST_RAISED;
            ST_RAISED: if (!fwd_next) state_nx = ST_QUIET;
            default:   state_nx = ST_QUIET;
        endcase
    end

    // outputs
    assign int_out = (state == ST_RAISED);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid      <= 1'b0;
            vec_out        <= '0;
            vec_from_slave <= 1'b0;
        end else begin
            vec_valid <= ack;
            if (ack) begin
                if (req_any) begin
                    vec_out        <= {vec_base[VEC_W-1:IW], req_top};
                    vec_from_slave <= cascade_map[req_top] && slave_present;
                end else begin
                    vec_out        <= {vec_base[VEC_W-1:IW], {IW{1'b1}}};
                    vec_from_slave <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/irq_prio_checker.sv
module irq_prio_checker #(
    parameter int N     = 8,
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack,
    input logic             auto_eoi,
    input logic [N-1:0]     mask,
    input logic [N-1:0]     req_q,
    input logic [N-1:0]     svc_q,
    input logic             int_out,
    input logic             vec_valid,
    input logic [VEC_W-1:0] vec_out,
    input logic             vec_from_slave
);
    assert_mask_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((req_q & ~$past(req_q) & $past(mask)) == '0));

    assert_raise_needs_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> (req_q != '0));

    assert_vec_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> vec_valid);

    assert_no_vec_without_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> !vec_valid);

    assert_auto_eoi_no_svc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && auto_eoi) |=> ((svc_q & ~$past(svc_q)) == '0));

    assert_spurious_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && req_q == '0) |=> (vec_out[2:0] == 3'd7 && !vec_from_slave && $stable(svc_q)));
endmodule

bind irq_prio_core irq_prio_checker #(.N(N), .VEC_W(VEC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ack(ack), .auto_eoi(auto_eoi), .mask(mask),
    .req_q(req_q), .svc_q(svc_q), .int_out(int_out), .vec_valid(vec_valid),
    .vec_out(vec_out), .vec_from_slave(vec_from_slave)
);

// File: tb/sim_irq_prio_core.sv
module sim_irq_prio_core;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] irq_pulse, mask, vec_base, cascade_map;
    logic       auto_eoi, slave_present, ack, eoi_valid, eoi_specific;
    logic [2:0] eoi_line;
    logic       int_out, vec_valid, vec_from_slave;
    logic [7:0] vec_out;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    irq_prio_core u0 (
        .clk(clk), .rst_n(rst_n), .irq_pulse(irq_pulse), .mask(mask),
        .vec_base(vec_base), .auto_eoi(auto_eoi), .cascade_map(cascade_map),
        .slave_present(slave_present), .ack(ack), .eoi_valid(eoi_valid),
        .eoi_specific(eoi_specific), .eoi_line(eoi_line), .int_out(int_out),
        .vec_valid(vec_valid), .vec_out(vec_out), .vec_from_slave(vec_from_slave)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; irq_pulse = '0; mask = '0; vec_base = 8'h20;
        cascade_map = '0; auto_eoi = 1'b0; slave_present = 1'b0; ack = 1'b0;
        eoi_valid = 1'b0; eoi_specific = 1'b0; eoi_line = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse(input logic [7:0] v);
        irq_pulse = v;
        @(negedge clk);
        irq_pulse = '0;
    endtask

    task automatic take_ack(input string tag, input int exp_vec, input int exp_slave);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk({tag, " valid"}, vec_valid, 1);
        chk({tag, " vector"}, vec_out, exp_vec);
        chk({tag, " slave"}, vec_from_slave, exp_slave);
    endtask

    task automatic eoi(input logic spec, input logic [2:0] ln);
        eoi_valid = 1'b1; eoi_specific = spec; eoi_line = ln;
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 int_out", int_out, 0);
        chk("R1 vec_valid", vec_valid, 0);
        take_ack("R1 empty", 8'h27, 0);
    endtask

    task automatic t_masked();
        do_reset();
        mask = 8'h08;
        pulse(8'h08);
        chk("R2 int_out", int_out, 0);
        take_ack("R2 nothing latched", 8'h27, 0);
    endtask

    task automatic t_nesting();
        do_reset();
        pulse(8'h08);
        chk("R3 raise", int_out, 1);
        repeat (3) @(negedge clk);
        chk("R13 held", int_out, 1);
        take_ack("R5 line3", 8'h23, 0);
        chk("R6 int low after ack", int_out, 0);
        pulse(8'h02);
        chk("R4 blocked below svc", int_out, 0);
        pulse(8'h20);
        chk("R4 above svc forwarded", int_out, 1);
        take_ack("R5 line5", 8'h25, 0);
        eoi(1'b0, 3'd0);
        pulse(8'h10);
        chk("R11 nonspecific cleared 5", int_out, 1);
        take_ack("R5 line4", 8'h24, 0);
        eoi(1'b1, 3'd4);
        chk("R4 still blocked by 3", int_out, 0);
        eoi(1'b1, 3'd3);
        chk("R10 specific eoi re-raise", int_out, 1);
        take_ack("R6 line1", 8'h21, 0);
        eoi(1'b0, 3'd0);
        take_ack("R6 requests cleared", 8'h27, 0);
    endtask

    task automatic t_priority();
        do_reset();
        pulse(8'h15);
        take_ack("R5 highest of 0,2,4", 8'h24, 0);
    endtask

    task automatic t_auto();
        do_reset();
        auto_eoi = 1'b1;
        pulse(8'h04);
        take_ack("R7 line2", 8'h22, 0);
        pulse(8'h02);
        chk("R7 no svc blocking", int_out, 1);
    endtask

    task automatic t_cascade();
        do_reset();
        cascade_map = 8'h04; slave_present = 1'b1;
        pulse(8'h04);
        take_ack("R8 slave", 8'h22, 1);
        slave_present = 1'b0;
        pulse(8'h04);
        take_ack("R8 no slave", 8'h22, 0);
    endtask

    task automatic t_collide();
        do_reset();
        pulse(8'h40);
        irq_pulse = 8'h01; ack = 1'b1;
        @(negedge clk);
        irq_pulse = '0; ack = 1'b0;
        chk("R12 vector", vec_out, 8'h26);
        chk("R12 blocked by 6", int_out, 0);
        eoi(1'b1, 3'd6);
        chk("R12 kept request raises", int_out, 1);
        take_ack("R12 line0", 8'h20, 0);
    endtask

    initial begin
        t_reset();
        t_masked();
        t_nesting();
        t_priority();
        t_auto();
        t_cascade();
        t_collide();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule